// File: doc/BRIEF.md
# Dual-Path Reset Sequencer

This block sits between reset requesters and a network datapath that has a transmit path, a receive path and a shared configuration area. It accepts three active-low asynchronous reset requests: a global cold request and one request for each direction. From these it drives three internal resets: the configuration reset and the transmit and receive core resets. Each internal reset goes low as soon as its request does. It is released through a synchroniser in the local clock domain.

Each request gets its own active-low acknowledge. The acknowledge goes low a fixed number of clock edges after the reset takes hold, and it returns high as soon as the request is released. Each direction has a status flag: transmit-stable and receive-ready. A flag drops as soon as its path is reset and rises again only after a settle interval once that path's reset has lifted. The cold request overrides both directions. A requester that releases before its acknowledge is flagged by a one-cycle error pulse on the error output of that request.

Top module: `dprs_reset_seq`

## Requirements
- R1: While `cold_req_n` is low, `cfg_rst_n`, `tx_rst_n` and `rx_rst_n` are all low, and they go low in the same time step as the request, without waiting for a clock edge.
- R2: While `cold_req_n` is low, `tx_stable` and `rx_ready` are both low.
- R3: A low `tx_req_n` with `cold_req_n` high drives `tx_rst_n` and `tx_stable` low at once. `rx_rst_n`, `rx_ready` and `cfg_rst_n` keep their values.
- R4: A low `rx_req_n` with `cold_req_n` high drives `rx_rst_n` and `rx_ready` low at once. `tx_rst_n`, `tx_stable` and `cfg_rst_n` keep their values.
- R5: When a request is released between two clock edges, its internal reset is still low after the first rising edge that follows. It is high after the second (SYNC_STAGES = 2).
- R6: An acknowledge output is high until ACK_CYC (default 8) rising edges have passed since its request went low, and it is low from then on while the request is held. It goes high in the same time step as the release of the request.
- R7: While `cold_req_n` is low, `tx_ack_n` and `rx_ack_n` both equal `cold_ack_n`, whatever the direction requests do.
- R8: A status flag goes high on the SETTLE_CYC-th (default 16) rising edge after the edge on which its internal reset lifted. If the reset is applied again during that window, the count starts over.
- R9: A request released after fewer than ACK_CYC edges raises its error output (1 = early release) for exactly one cycle. The pulse starts at the second rising edge after the release. A release after ACK_CYC or more edges raises no error.
- R10: A cold early release is reported only on `cold_err`. `tx_err` and `rx_err` stay low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for synchronisers and timers |
| cold_req_n | input | 1 | Global cold reset request, active low, asynchronous |
| tx_req_n | input | 1 | Transmit-path reset request, active low, asynchronous |
| rx_req_n | input | 1 | Receive-path reset request, active low, asynchronous |
| cfg_rst_n | output | 1 | Reset of configuration and transceiver reconfiguration state |
| tx_rst_n | output | 1 | Reset of the transmit MAC and PCS |
| rx_rst_n | output | 1 | Reset of the receive MAC and PCS |
| cold_ack_n | output | 1 | Acknowledge of the cold request, active low |
| tx_ack_n | output | 1 | Acknowledge of the transmit request, active low |
| rx_ack_n | output | 1 | Acknowledge of the receive request, active low |
| tx_stable | output | 1 | Transmit lanes settled |
| rx_ready | output | 1 | Receive path ready |
| cold_err | output | 1 | One-cycle pulse: cold request released early |
| tx_err | output | 1 | One-cycle pulse: transmit request released early |
| rx_err | output | 1 | One-cycle pulse: receive request released early |

## Verification
The embedded properties check several rules on every clock edge. An acknowledge is never low unless its internal reset is applied. A held cold request forces every internal reset and both status flags low. An internal reset rises only from the synchroniser's last pending stage. A status flag or an error pulse appears only after its reset has lifted. The exact edge counts can only be shown by the bench's scenarios: when the acknowledge arrives, when the reset is released, the settle interval and where the error pulse falls. The same holds for the isolation of the untouched direction, for the restart of an interrupted settle window and for a cold request that overrides a direction request already acknowledged.

// File: rtl/dprs_pkg.sv
package dprs_pkg;

  // Number of bits that hold a count from 0 up to n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True when the count in hand is the last one of a window of 'limit' edges.
  function automatic logic at_limit(input int unsigned value, input int unsigned limit);
    return (value + 1) >= limit;
  endfunction

  // Length of the hold history: the acknowledge window plus the edges spent in the synchroniser.
  function automatic int unsigned hold_depth(input int unsigned ack_cyc, input int unsigned stages);
    return ack_cyc + stages - 1;
  endfunction

endpackage

// File: rtl/dprs_sync.sv
module dprs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o,
  output logic pend_o
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= '0;
    else         stg <= {stg[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = stg[STAGES-1];
  assign pend_o  = stg[STAGES-2];

  // R5
  release_two_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(pend_o));
endmodule

// File: rtl/dprs_ack.sv
module dprs_ack
  import dprs_pkg::*;
#(
  parameter int unsigned ACK_CYC = 8,
  parameter int unsigned STAGES  = 2
) (
  input  logic clk,
  input  logic req_n,
  input  logic core_rst_n,
  input  logic pend,
  output logic ack_n,
  output logic early_o
);
  localparam int unsigned SH_W = hold_depth(ACK_CYC, STAGES);

  logic [SH_W-1:0] held;
  logic            early_q;
  logic            acked;
  logic            lift_now;
  logic            short_hold;

  // Thermometer of edges spent in reset: fills with ones and needs no initial value.
  always_ff @(posedge clk) begin
    if (core_rst_n) held <= '0;
    else            held <= {held[SH_W-2:0], 1'b1};
  end

  assign acked      = held[ACK_CYC-1];
  assign ack_n      = req_n | ~acked;
  assign lift_now   = pend & ~core_rst_n;
  assign short_hold = ~held[SH_W-1];

  always_ff @(posedge clk) early_q <= lift_now & short_hold;
  assign early_o = early_q;

  // R6
  ack_needs_reset_chk: assert property (@(posedge clk) disable iff (req_n)
    !ack_n |-> !core_rst_n);

  // R9
  early_after_lift_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    early_q |-> $past(!core_rst_n));
endmodule

// File: rtl/dprs_settle.sv
module dprs_settle
  import dprs_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic core_rst_n,
  output logic ready_o
);
  localparam int unsigned CW = cnt_width(SETTLE_CYC);

  logic [CW-1:0] cnt;
  logic          ready_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cnt     <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (at_limit(int'(cnt), SETTLE_CYC)) ready_q <= 1'b1;
      else                                 cnt     <= cnt + 1'b1;
    end
  end

  assign ready_o = ready_q;

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(ready_o) |-> $past(core_rst_n));
endmodule

// File: rtl/dprs_reset_seq.sv
module dprs_reset_seq #(
  parameter int unsigned ACK_CYC     = 8,
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic cold_req_n,
  input  logic tx_req_n,
  input  logic rx_req_n,
  output logic cfg_rst_n,
  output logic tx_rst_n,
  output logic rx_rst_n,
  output logic cold_ack_n,
  output logic tx_ack_n,
  output logic rx_ack_n,
  output logic tx_stable,
  output logic rx_ready,
  output logic cold_err,
  output logic tx_err,
  output logic rx_err
);
  localparam int unsigned NPATH = 2;

  logic             cold_pend;
  logic             cold_early;
  logic [NPATH-1:0] eff_n;
  logic [NPATH-1:0] path_rst_n;
  logic [NPATH-1:0] path_pend;
  logic [NPATH-1:0] path_ack_n;
  logic [NPATH-1:0] path_early;
  logic [NPATH-1:0] path_rdy;

  // Cold domain: configuration reset
  dprs_sync #(.STAGES(SYNC_STAGES)) u_cold_sync (
    .clk(clk), .arst_n(cold_req_n), .rst_n_o(cfg_rst_n), .pend_o(cold_pend)
  );

  dprs_ack #(.ACK_CYC(ACK_CYC), .STAGES(SYNC_STAGES)) u_cold_ack (
    .clk(clk), .req_n(cold_req_n), .core_rst_n(cfg_rst_n), .pend(cold_pend),
    .ack_n(cold_ack_n), .early_o(cold_early)
  );

  // Index 0 is transmit, index 1 is receive; the cold request folds into both
  assign eff_n[0] = tx_req_n & cold_req_n;
  assign eff_n[1] = rx_req_n & cold_req_n;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    dprs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(eff_n[g]), .rst_n_o(path_rst_n[g]), .pend_o(path_pend[g])
    );
    dprs_ack #(.ACK_CYC(ACK_CYC), .STAGES(SYNC_STAGES)) u_ack (
      .clk(clk), .req_n(eff_n[g]), .core_rst_n(path_rst_n[g]), .pend(path_pend[g]),
      .ack_n(path_ack_n[g]), .early_o(path_early[g])
    );
    dprs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .core_rst_n(path_rst_n[g]), .ready_o(path_rdy[g])
    );
  end

  assign tx_rst_n  = path_rst_n[0];
  assign rx_rst_n  = path_rst_n[1];
  assign tx_stable = path_rdy[0];
  assign rx_ready  = path_rdy[1];

  // While the cold request is held, the direction acknowledges track the cold one
  assign tx_ack_n = cold_req_n ? path_ack_n[0] : cold_ack_n;
  assign rx_ack_n = cold_req_n ? path_ack_n[1] : cold_ack_n;

  assign cold_err = cold_early;
  assign tx_err   = path_early[0] & ~cold_early;
  assign rx_err   = path_early[1] & ~cold_early;

  // R1
  cold_forces_all_chk: assert property (@(posedge clk) disable iff (cold_req_n)
    !cold_req_n |-> (!cfg_rst_n && !tx_rst_n && !rx_rst_n));

  // R2
  cold_drops_status_chk: assert property (@(posedge clk) disable iff (cold_req_n)
    !cold_req_n |-> (!tx_stable && !rx_ready));
endmodule

// File: tb/dprs_reset_seq_tb.sv
module dprs_reset_seq_tb;
  localparam int ACK    = 8;
  localparam int SETTLE = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic cold_n, tx_n, rx_n;
  logic cfg_rst_n, tx_rst_n, rx_rst_n;
  logic cold_ack_n, tx_ack_n, rx_ack_n;
  logic tx_stable, rx_ready, cold_err, tx_err, rx_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dprs_reset_seq #(.ACK_CYC(ACK), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .cold_req_n(cold_n), .tx_req_n(tx_n), .rx_req_n(rx_n),
    .cfg_rst_n(cfg_rst_n), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
    .cold_ack_n(cold_ack_n), .tx_ack_n(tx_ack_n), .rx_ack_n(rx_ack_n),
    .tx_stable(tx_stable), .rx_ready(rx_ready),
    .cold_err(cold_err), .tx_err(tx_err), .rx_err(rx_err)
  );

  // Expected values restated from the requirements
  function automatic logic exp_ack_n(input int edges); return !(edges >= ACK); endfunction
  function automatic logic exp_err(input int held);    return held < ACK;       endfunction
  function automatic logic exp_rdy(input int edges);   return edges >= SETTLE;  endfunction

  // Path codes: 0 transmit, 1 receive, 2 cold
  function automatic logic rst_of(input int p);
    return (p == 0) ? tx_rst_n : (p == 1) ? rx_rst_n : cfg_rst_n;
  endfunction
  function automatic logic ack_of(input int p);
    return (p == 0) ? tx_ack_n : (p == 1) ? rx_ack_n : cold_ack_n;
  endfunction
  function automatic logic err_of(input int p);
    return (p == 0) ? tx_err : (p == 1) ? rx_err : cold_err;
  endfunction
  function automatic string tag_of(input int p);
    return (p == 0) ? "R3" : (p == 1) ? "R4" : "R1";
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input int p, input logic v);
    case (p)
      0: tx_n = v;
      1: rx_n = v;
      default: cold_n = v;
    endcase
  endtask

  task automatic check_status(input int p, input string req, input logic exp);
    if (p != 1) check(req, "tx_stable", tx_stable, exp);
    if (p != 0) check(req, "rx_ready", rx_ready, exp);
  endtask

  // Hold request p for k edges, release, then follow release, error and settle timing
  task automatic pulse(input int p, input int k);
    @(negedge clk);
    drive(p, 1'b0);
    #1;
    check(tag_of(p), "internal reset applied at once", rst_of(p), 1'b0);
    if (p == 0) begin
      check("R3", "rx_rst_n untouched", rx_rst_n, 1'b1);
      check("R3", "rx_ready untouched", rx_ready, 1'b1);
      check("R3", "cfg_rst_n untouched", cfg_rst_n, 1'b1);
    end else if (p == 1) begin
      check("R4", "tx_rst_n untouched", tx_rst_n, 1'b1);
      check("R4", "tx_stable untouched", tx_stable, 1'b1);
      check("R4", "cfg_rst_n untouched", cfg_rst_n, 1'b1);
    end else begin
      check("R1", "tx_rst_n by cold", tx_rst_n, 1'b0);
      check("R1", "rx_rst_n by cold", rx_rst_n, 1'b0);
    end
    for (int e = 1; e <= k; e++) begin
      @(negedge clk);
      check("R6", "ack timing", ack_of(p), exp_ack_n(e));
      check_status(p, (p == 2) ? "R2" : tag_of(p), 1'b0);
      if (p == 2) begin
        check("R7", "tx_ack follows cold", tx_ack_n, exp_ack_n(e));
        check("R7", "rx_ack follows cold", rx_ack_n, exp_ack_n(e));
      end
    end
    drive(p, 1'b1);
    #1;
    check("R6", "ack released with request", ack_of(p), 1'b1);
    @(negedge clk);
    check("R5", "still in reset after first edge", rst_of(p), 1'b0);
    @(negedge clk);
    check("R5", "released after second edge", rst_of(p), 1'b1);
    check("R9", "early-release pulse", err_of(p), exp_err(k));
    if (p == 2) begin
      check("R10", "tx_err masked", tx_err, 1'b0);
      check("R10", "rx_err masked", rx_err, 1'b0);
    end
    for (int j = 1; j <= SETTLE; j++) begin
      @(negedge clk);
      if (j == 1) check("R9", "pulse lasts one cycle", err_of(p), 1'b0);
      check_status(p, "R8", exp_rdy(j));
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    cold_n = 1'b1; tx_n = 1'b1; rx_n = 1'b1;
    #3;
    cold_n = 1'b0; tx_n = 1'b0; rx_n = 1'b0;
    repeat (20) @(negedge clk);
    // Reset state
    check("R1", "cfg_rst_n at power-up", cfg_rst_n, 1'b0);
    check("R1", "tx_rst_n at power-up", tx_rst_n, 1'b0);
    check("R2", "tx_stable at power-up", tx_stable, 1'b0);
    check("R2", "rx_ready at power-up", rx_ready, 1'b0);
    check("R6", "cold ack held", cold_ack_n, 1'b0);
    check("R7", "tx ack with cold", tx_ack_n, 1'b0);
    cold_n = 1'b1; tx_n = 1'b1; rx_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R5", "all released", cfg_rst_n & tx_rst_n & rx_rst_n, 1'b1);
    check("R9", "no error after long hold", cold_err | tx_err | rx_err, 1'b0);
    repeat (SETTLE) @(negedge clk);
    check("R8", "tx_stable settled", tx_stable, 1'b1);
    check("R8", "rx_ready settled", rx_ready, 1'b1);

    // Directed edge of the acknowledge window
    pulse(1, ACK - 1);
    pulse(1, ACK);
    pulse(0, 1);
    pulse(2, ACK - 3);
    pulse(2, ACK + 2);

    // R8: interrupted settle window restarts
    @(negedge clk);
    tx_n = 1'b0;
    repeat (ACK + 1) @(negedge clk);
    tx_n = 1'b1;
    repeat (2 + 5) @(negedge clk);
    check("R8", "not settled mid-window", tx_stable, 1'b0);
    pulse(0, ACK + 1);

    // R7: cold overrides an already acknowledged transmit request
    @(negedge clk);
    tx_n = 1'b0;
    repeat (ACK + 2) @(negedge clk);
    check("R6", "tx acked alone", tx_ack_n, 1'b0);
    cold_n = 1'b0;
    #1;
    check("R7", "tx ack follows fresh cold", tx_ack_n, 1'b1);
    check("R7", "rx ack follows fresh cold", rx_ack_n, 1'b1);
    for (int e = 1; e <= ACK + 1; e++) begin
      @(negedge clk);
      check("R7", "tx ack tracks cold", tx_ack_n, exp_ack_n(e));
      check("R7", "rx ack tracks cold", rx_ack_n, exp_ack_n(e));
    end
    cold_n = 1'b1;
    #1;
    check("R6", "tx still acked after cold ends", tx_ack_n, 1'b0);
    repeat (3) @(negedge clk);
    check("R3", "tx held in reset by own request", tx_rst_n, 1'b0);
    check("R3", "rx back out of reset", rx_rst_n, 1'b1);
    check("R1", "cfg back out of reset", cfg_rst_n, 1'b1);
    tx_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R5", "tx released", tx_rst_n, 1'b1);
    check("R9", "no tx error after long hold", tx_err, 1'b0);
    repeat (SETTLE + 2) @(negedge clk);
    check("R8", "tx settled again", tx_stable, 1'b1);
    check("R8", "rx settled again", rx_ready, 1'b1);

    // Constrained random requests
    for (int it = 0; it < 24; it++) begin
      int p;
      int k;
      p = $urandom_range(0, 2);
      k = $urandom_range(1, ACK + 4);
      pulse(p, k);
      repeat ($urandom_range(1, 4)) @(negedge clk);
    end

    done = 1'b1;
    finish_run();
  end
endmodule